// File: doc/BRIEF.md
# Steerable watchdog timer

This block is a watchdog with a byte-wide control register. Software writes a timeout code into the register. The block then counts strobes on a 16 Hz tick input. If no access to the register restarts the count before the timeout ends, the watchdog expires. Bit 7 of the register picks what happens on expiry. When it is set, the block requests a system reset, clears its own register and asks the clock core to clear bit 6 of its day register. When it is clear, the block emits a single interrupt pulse and keeps its register.

The timeout code has three fields. Bits 1:0 select a resolution of 4^n ticks. Bits 6:2 hold a five-bit multiplier. Bit 7 is the steering bit. Both a write and a read of the register restart the count. A register value of zero, or a multiplier of zero, leaves the watchdog idle. On every expiry the block raises a flag output that the clock core shows as bit 7 of its flags register. The flag stays up until the next access to the register.

Top module: `wdog_steer_top`

## Requirements
- R1: The timeout, counted in ticks, is mult * 4^res, with res = bits 1:0 and mult = bits 6:2 of the register. Expiry happens on the edge that takes in the timeout-th tick strobe after the last access. Cycles without a tick do not advance the count.
- R2: When the register is zero, or its multiplier field is zero, the block never expires, however many ticks arrive.
- R3: A write stores the byte, which is readable on `reg_rdata` from the next cycle. The write also reloads the count from the new value and clears the flag.
- R4: A read leaves the stored byte unchanged. It restarts the count from the stored value and clears the flag.
- R5: On expiry the flag goes high. It stays high until the next write or read.
- R6: On expiry with bit 7 set, `rst_req` and `day_bit6_clr` are each high for exactly one cycle and the register reads back as 0x00.
- R7: On expiry with bit 7 clear, `irq_pulse` is high for exactly one cycle. The register keeps its value and no reset is requested. The count then stops until the next access.
- R8: A write or read in the same cycle as the final tick takes priority: the count reloads and no expiry happens in that cycle.
- R9: Synchronous reset clears the register, the count, the flag and all pulse outputs. A count interrupted by reset does not expire afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16hz | input | 1 | One-cycle strobe, one per 1/16 second |
| reg_wr | input | 1 | Write strobe for the watchdog register |
| reg_rd | input | 1 | Read strobe; restarts the count |
| reg_wdata | input | 8 | Write data: steer bit 7, multiplier 6:2, resolution 1:0 |
| reg_rdata | output | 8 | Current register contents |
| wd_flag | output | 1 | Expiry flag (bit 7 of the flags register) |
| rst_req | output | 1 | One-cycle system reset request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| day_bit6_clr | output | 1 | One-cycle request to clear bit 6 of the day register |

## Verification
`reg_rdata` shows a write from the cycle after the edge that takes it in. The flag and all three pulse outputs are registered, so they change one cycle after the edge that samples the final tick strobe or the restarting access. For every cycle it drives, the bench pushes the expected values for that one cycle into a queue. The monitor compares them 1 ns after the next rising edge, so each result is checked in the cycle it is due and is never early or late.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_DATA_W = 8;
    localparam int WD_MULT_W = 5;
    localparam int WD_RES_W  = 2;
    localparam int WD_CNT_W  = 16;

    // Register layout: steering bit on top, multiplier, resolution at the bottom
    typedef struct packed {
        logic                 steer;
        logic [WD_MULT_W-1:0] mult;
        logic [WD_RES_W-1:0]  res;
    } wd_cfg_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } wd_access_e;

    // Ticks until expiry: multiplier scaled by four to the power res
    function automatic logic [WD_CNT_W-1:0] wd_timeout(input wd_cfg_t c);
        logic [WD_CNT_W-1:0] base;
        base = WD_CNT_W'(c.mult);
        return base << {c.res, 1'b0};
    endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
    import wdog_pkg::*;
#(
    parameter int DATA_W = WD_DATA_W,
    parameter int CNT_W  = WD_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wipe,
    output wd_cfg_t           cfg,
    output wd_access_e        access,
    output logic [CNT_W-1:0]  load_val
);
    localparam int CFG_W = $bits(wd_cfg_t);

    wd_cfg_t wcfg;
    assign wcfg = wd_cfg_t'(wdata[CFG_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr_en)
            cfg <= wcfg;
        else if (wipe)
            cfg <= '0;
    end

    always_comb begin
        if (wr_en)      access = ACC_WRITE;
        else if (rd_en) access = ACC_READ;
        else            access = ACC_NONE;
    end

    assign load_val = CNT_W'(wd_timeout(wr_en ? wcfg : cfg));

    AST_READ_KEEPS_REG: assert property (@(posedge clk) disable iff (rst)
        (access == ACC_READ) |=> $stable(cfg)) else $error("read changed register"); // R4

endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int CNT_W = wdog_pkg::WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // A reload wins over the final tick of the previous count
    assign expire = tick && !load && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && (cnt != '0))
            cnt <= cnt - LAST;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && !load) |=> (cnt == '0)) else $error("idle counter moved"); // R2
    AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt)) else $error("count moved without tick"); // R1

endmodule

// File: rtl/wdog_expiry_act.sv
module wdog_expiry_act (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    input  logic access_any,
    output logic wipe,
    output logic flag,
    output logic rst_req,
    output logic irq_pulse,
    output logic day_clr
);
    assign wipe = expire && steer;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag      <= 1'b0;
            rst_req   <= 1'b0;
            irq_pulse <= 1'b0;
            day_clr   <= 1'b0;
        end else begin
            rst_req   <= expire && steer;
            day_clr   <= expire && steer;
            irq_pulse <= expire && !steer;
            if (access_any)
                flag <= 1'b0;
            else if (expire)
                flag <= 1'b1;
        end
    end

    AST_STEER_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq_pulse)) else $error("both expiry actions"); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse) else $error("irq longer than one cycle"); // R7
    AST_DAY_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> day_clr) else $error("day clear missing"); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        access_any |=> !flag) else $error("flag not cleared by access"); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (expire && !access_any) |=> flag) else $error("flag not set on expiry"); // R5

endmodule

// File: rtl/wdog_steer_top.sv
module wdog_steer_top
    import wdog_pkg::*;
#(
    parameter int DATA_W = WD_DATA_W,
    parameter int CNT_W  = WD_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16hz,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wd_flag,
    output logic              rst_req,
    output logic              irq_pulse,
    output logic              day_bit6_clr
);
    wd_cfg_t          cfg;
    wd_access_e       access;
    logic [CNT_W-1:0] load_val;
    logic             access_any;
    logic             expire;
    logic             wipe;

    assign access_any = (access != ACC_NONE);
    assign reg_rdata  = DATA_W'(cfg);

    wdog_cfg_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_reg (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .wdata(reg_wdata),
        .wipe(wipe), .cfg(cfg), .access(access), .load_val(load_val)
    );

    wdog_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(access_any), .load_val(load_val),
        .tick(tick_16hz), .expire(expire)
    );

    wdog_expiry_act u_act (
        .clk(clk), .rst(rst), .expire(expire), .steer(cfg.steer),
        .access_any(access_any), .wipe(wipe), .flag(wd_flag), .rst_req(rst_req),
        .irq_pulse(irq_pulse), .day_clr(day_bit6_clr)
    );

    AST_RESET_WIPES_REG: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (reg_rdata == '0)) else $error("register kept after reset request"); // R6

endmodule

// File: tb/tb_wdog_steer_top.sv
`timescale 1ns/1ps
module tb_wdog_steer_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16hz = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wd_flag, rst_req, irq_pulse, day_bit6_clr;

    always #2.5 clk = ~clk;

    wdog_steer_top dut (
        .clk(clk), .rst(rst), .tick_16hz(tick_16hz), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wd_flag(wd_flag),
        .rst_req(rst_req), .irq_pulse(irq_pulse), .day_bit6_clr(day_bit6_clr)
    );

    typedef struct {
        logic [7:0] rdata;
        logic       flag;
        logic       rreq;
        logic       irq;
        logic       dclr;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Reference state derived from the requirements
    logic [7:0] m_reg  = 8'h00;
    int         m_cnt  = 0;
    bit         m_flag = 1'b0;

    function automatic int tmo(input logic [7:0] v);
        return int'(v[6:2]) << (2 * int'(v[1:0]));
    endfunction

    task automatic step(input bit r, input bit w, input bit rd, input logic [7:0] d,
                        input bit t, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; reg_wr = w; reg_rd = rd; reg_wdata = d; tick_16hz = t;
        e.rreq = 1'b0; e.irq = 1'b0; e.dclr = 1'b0;
        if (r) begin
            m_reg = 8'h00; m_cnt = 0; m_flag = 1'b0;
        end else if (w) begin
            m_reg = d; m_cnt = tmo(d); m_flag = 1'b0;
        end else if (rd) begin
            m_cnt = tmo(m_reg); m_flag = 1'b0;
        end else if (t && m_cnt != 0) begin
            if (m_cnt == 1) begin
                m_flag = 1'b1;
                if (m_reg[7]) begin
                    e.rreq = 1'b1; e.dclr = 1'b1; m_reg = 8'h00;
                end else begin
                    e.irq = 1'b1;
                end
            end
            m_cnt = m_cnt - 1;
        end
        e.rdata = m_reg; e.flag = m_flag; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic ticks(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, tag);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, tag);
        end
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, 1'b0, d, 1'b0, tag);
    endtask

    // Monitor: compares each queued expectation just after the edge it is due
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            mon_e = sbq.pop_front();
            n_chk++;
            if (reg_rdata !== mon_e.rdata || wd_flag !== mon_e.flag ||
                rst_req !== mon_e.rreq || irq_pulse !== mon_e.irq ||
                day_bit6_clr !== mon_e.dclr) begin
                n_fail++;
                $display("FAIL %s: got rdata=%h flag=%b rreq=%b irq=%b dclr=%b, expected rdata=%h flag=%b rreq=%b irq=%b dclr=%b",
                         mon_e.tag, reg_rdata, wd_flag, rst_req, irq_pulse, day_bit6_clr,
                         mon_e.rdata, mon_e.flag, mon_e.rreq, mon_e.irq, mon_e.dclr);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
        // R1/R7: 4-tick timeout, interrupt mode
        wr(8'h05, "R3");
        ticks(4, 0, "R1_R7");
        // R5/R7: flag holds, no further pulse
        ticks(6, 1, "R5_R7");
        // R3: write clears flag, reg readable
        wr(8'h0A, "R3");
        ticks(31, 0, "R1");
        // R4: read restarts count
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R4");
        ticks(31, 0, "R4");
        ticks(1, 0, "R4_R1");
        ticks(3, 0, "R7");
        // R2: zero multiplier and zero register
        wr(8'h83, "R2");
        ticks(100, 0, "R2");
        wr(8'h00, "R2");
        ticks(50, 0, "R2");
        // R6: reset steering
        wr(8'h86, "R3");
        ticks(16, 0, "R6");
        ticks(20, 0, "R6");
        // R8: access coincides with final tick
        wr(8'h04, "R8");
        step(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
        step(1'b0, 1'b1, 8'h00 == 8'h00 ? 1'b0 : 1'b0, 8'h04, 1'b1, "R8");
        ticks(1, 0, "R8");
        // R1: sparse ticks
        wr(8'h09, "R1");
        ticks(8, 2, "R1");
        // R1: largest timeout
        wr(8'h7F, "R1");
        ticks(1984, 0, "R1");
        ticks(2, 0, "R7");
        // R9: reset during a count
        wr(8'h89, "R9");
        ticks(3, 0, "R9");
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
        ticks(20, 0, "R9");
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule